// File: doc/BRIEF.md
# Recirculating Buffer Wavelength Allocator

This block is the electronic controller for a bank of recirculating shared-buffer modules in a slotted packet switch. Each module holds packets on a fixed set of wavelengths, one packet per wavelength. The block tracks which wavelength of which module is in use. In each slot it can take one buffer-write request that names the packet's output destination. It answers in the same slot with either a (module, wavelength) assignment or a drop. The assignment is the tuning code for the converter at the buffer input.

For every output the block keeps a first-in, first-out list of the (module, wavelength) tags of the packets buffered for that output. When the surrounding scheduler marks an output as free for the slot, the block grants the oldest tag of that output. That tag is the tuning code for the read-side converter. The wavelength is released in that same slot. A write arriving in the same slot may reuse the released wavelength at once, because reads are resolved before the write.

The write stream is valid-only with no back-pressure. Every valid request is resolved in its own slot as either a grant or a drop, so no ready signal exists. Read grants are a plain per-output strobe qualified by `out_free`.

Top module: `loopbuf_alloc`

## Requirements
- R1: After reset every wavelength is free, every output list is empty, and `wr_grant`, `wr_drop` and `rd_valid` are all low.
- R2: A valid write is granted in the same cycle. The grant goes to the lowest-numbered module that has a free wavelength, and within that module to its lowest-numbered free wavelength. The slot order is module-major: slot = module*NUM_WL + wavelength.
- R3: When every wavelength of every module is occupied (after the same-cycle releases), a valid write gives `wr_drop`=1 and `wr_grant`=0, and occupancy is unchanged.
- R4: A granted wavelength stays occupied and is never granted again until the packet on it is read out.
- R5: An output whose list is non-empty and whose `out_free` bit is high gets `rd_valid`=1 with the head tag on its `rd_mod`/`rd_wl` lanes. There is at most one read per output per cycle.
- R6: The read grants of an output return that output's tags in the order their writes were granted.
- R7: While an output's `out_free` bit is low, its `rd_valid` stays low and its list is kept unchanged.
- R8: A wavelength is released in the cycle it is read. A write in that same cycle may be granted that wavelength.
- R9: Different outputs are read independently in the same cycle.
- R10: With `wr_valid` low, no wavelength is taken and neither `wr_grant` nor `wr_drop` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Buffer-write request present this slot |
| wr_dest | input | DEST_W | Output destination of the packet to buffer |
| wr_grant | output | 1 | Request granted a wavelength |
| wr_drop | output | 1 | Request dropped, buffer full |
| wr_mod | output | MOD_W | Granted module index |
| wr_wl | output | WL_W | Granted wavelength index (input converter tuning code) |
| out_free | input | NUM_OUT | Per-output: output available for a read-out this slot |
| rd_valid | output | NUM_OUT | Per-output read-out grant |
| rd_mod | output | NUM_OUT*MOD_W | Per-output module of the head packet, lane o at [o*MOD_W +: MOD_W] |
| rd_wl | output | NUM_OUT*WL_W | Per-output wavelength of the head packet (read converter tuning code) |

## Verification
A single-destination burst larger than one module shows the module-major fill order. The read-back of that burst shows per-output ordering. Writes spread round-robin over four outputs until the buffer is full show drop behaviour, and then the same-cycle read-then-write reuse of a released wavelength. Further patterns gate `out_free` low, read several outputs at once, and send idle slots between writes. These separate blocked from independent read-out and no-request slots from drops. A reference model in the bench predicts every grant and tag, so a wrong priority, a stale occupancy bit or a reordered list shows up as a tag mismatch.

// File: rtl/loopbuf_pkg.sv
package loopbuf_pkg;
  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/loopbuf_pick.sv
module loopbuf_pick
  import loopbuf_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int NUM_WL  = 8,
  localparam int MOD_W  = width_of(NUM_MOD),
  localparam int WL_W   = width_of(NUM_WL),
  localparam int SLOTS  = NUM_MOD * NUM_WL,
  localparam int IDX_W  = width_of(SLOTS)
) (
  input  logic [SLOTS-1:0] avail,
  output logic             found,
  output logic [MOD_W-1:0] mod_o,
  output logic [WL_W-1:0]  wl_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from the top down so the lowest slot is the last one assigned
  always_comb begin
    found = 1'b0;
    mod_o = '0;
    wl_o  = '0;
    idx_o = '0;
    for (int m = NUM_MOD - 1; m >= 0; m--) begin
      for (int w = NUM_WL - 1; w >= 0; w--) begin
        if (avail[m*NUM_WL + w]) begin
          found = 1'b1;
          mod_o = MOD_W'(m);
          wl_o  = WL_W'(w);
          idx_o = IDX_W'(m*NUM_WL + w);
        end
      end
    end
  end
endmodule

// File: rtl/loopbuf_tagq.sv
module loopbuf_tagq
  import loopbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 5,
  localparam int PTR_W = width_of(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic [CNT_W-1:0] cnt
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rp, wp;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rp];
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // R6: the list never overruns or underruns, so no tag is lost or repeated
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (int'(cnt) < DEPTH));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/loopbuf_alloc.sv
module loopbuf_alloc
  import loopbuf_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int NUM_MOD = 4,
  parameter int NUM_WL  = 8,
  localparam int DEST_W = width_of(NUM_OUT),
  localparam int MOD_W  = width_of(NUM_MOD),
  localparam int WL_W   = width_of(NUM_WL),
  localparam int SLOTS  = NUM_MOD * NUM_WL,
  localparam int IDX_W  = width_of(SLOTS),
  localparam int TAG_W  = MOD_W + WL_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [DEST_W-1:0]        wr_dest,
  output logic                     wr_grant,
  output logic                     wr_drop,
  output logic [MOD_W-1:0]         wr_mod,
  output logic [WL_W-1:0]          wr_wl,
  input  logic [NUM_OUT-1:0]       out_free,
  output logic [NUM_OUT-1:0]       rd_valid,
  output logic [NUM_OUT*MOD_W-1:0] rd_mod,
  output logic [NUM_OUT*WL_W-1:0]  rd_wl
);
  logic [SLOTS-1:0] occ, rel, avail;
  logic             found;
  logic [IDX_W-1:0] pick_idx;
  logic [TAG_W-1:0] head [NUM_OUT];
  logic [CNT_W-1:0] qcnt [NUM_OUT];
  logic [NUM_OUT-1:0] qempty;

  // per-output ordered tag lists
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic push;
    assign push        = wr_grant && (int'(wr_dest) == o);
    assign rd_valid[o] = !qempty[o] && out_free[o];
    assign rd_mod[o*MOD_W +: MOD_W] = head[o][TAG_W-1 -: MOD_W];
    assign rd_wl[o*WL_W +: WL_W]    = head[o][WL_W-1:0];

    loopbuf_tagq #(.DEPTH(SLOTS), .W(TAG_W)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .din  ({wr_mod, wr_wl}),
      .pop  (rd_valid[o]),
      .head (head[o]),
      .empty(qempty[o]),
      .cnt  (qcnt[o])
    );
  end

  // reads are resolved first: their slots are free for this cycle's write
  always_comb begin
    rel = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int m = 0; m < NUM_MOD; m++) begin
        for (int w = 0; w < NUM_WL; w++) begin
          if (rd_valid[o] && int'(head[o][TAG_W-1 -: MOD_W]) == m &&
              int'(head[o][WL_W-1:0]) == w)
            rel[m*NUM_WL + w] = 1'b1;
        end
      end
    end
  end

  assign avail = ~occ | rel;

  loopbuf_pick #(.NUM_MOD(NUM_MOD), .NUM_WL(NUM_WL)) u_pick (
    .avail(avail),
    .found(found),
    .mod_o(wr_mod),
    .wl_o (wr_wl),
    .idx_o(pick_idx)
  );

  assign wr_grant = wr_valid && found;
  assign wr_drop  = wr_valid && !found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      occ <= (occ & ~rel) | (wr_grant ? (SLOTS'(1) << pick_idx) : '0);
    end
  end

  // total queued tags, counted independently of the occupancy vector
  logic [31:0] queued;
  always_comb begin
    queued = '0;
    for (int o = 0; o < NUM_OUT; o++) queued = queued + 32'(qcnt[o]);
  end

  // R3: a request is either granted or dropped, never both
  assert_grant_xor_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_drop));
  // R3: a drop with no read-out leaves occupancy as it was
  assert_drop_keeps_occ_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && rd_valid == '0) |=> $stable(occ));
  // R4: a granted slot is held in the next cycle
  assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |=> occ[$past(pick_idx)]);
  // R4: every occupied wavelength has exactly one queued tag
  assert_occ_matches_lists_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == int'(queued));
  // R10: no request, no outcome
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !(wr_grant || wr_drop));
endmodule

// File: tb/test_loopbuf_alloc.sv
module test_loopbuf_alloc;
  localparam int NUM_OUT = 16;
  localparam int NUM_MOD = 4;
  localparam int NUM_WL  = 8;
  localparam int SLOTS   = NUM_MOD * NUM_WL;
  localparam int MOD_W   = 2;
  localparam int WL_W    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [3:0] wr_dest = '0;
  logic wr_grant, wr_drop;
  logic [MOD_W-1:0] wr_mod;
  logic [WL_W-1:0] wr_wl;
  logic [NUM_OUT-1:0] out_free = '0;
  logic [NUM_OUT-1:0] rd_valid;
  logic [NUM_OUT*MOD_W-1:0] rd_mod;
  logic [NUM_OUT*WL_W-1:0] rd_wl;

  int checks = 0;
  int errors = 0;

  // reference model
  bit occ_m [SLOTS];
  int qs [NUM_OUT][$];

  always #2.5 clk = ~clk;

  loopbuf_alloc #(.NUM_OUT(NUM_OUT), .NUM_MOD(NUM_MOD), .NUM_WL(NUM_WL)) i_loopbuf_alloc (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_dest(wr_dest),
    .wr_grant(wr_grant), .wr_drop(wr_drop), .wr_mod(wr_mod), .wr_wl(wr_wl),
    .out_free(out_free), .rd_valid(rd_valid), .rd_mod(rd_mod), .rd_wl(rd_wl)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one slot: drive, predict, compare, advance model
  task automatic step(input bit v, input int dest, input logic [NUM_OUT-1:0] fr, input string req);
    bit rel [SLOTS];
    int exp_rd [NUM_OUT];
    logic [NUM_OUT-1:0] exp_rv;
    int pick;
    @(negedge clk);
    wr_valid = v;
    wr_dest  = 4'(dest);
    out_free = fr;
    foreach (rel[i]) rel[i] = 0;
    exp_rv = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      exp_rd[o] = -1;
      if (fr[o] && qs[o].size() > 0) begin
        exp_rv[o] = 1'b1;
        exp_rd[o] = qs[o][0];
        rel[qs[o][0]] = 1;
      end
    end
    pick = -1;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!occ_m[i] || rel[i]) pick = i;
    #1;
    check(rd_valid == exp_rv, req, "rd_valid", int'(rd_valid), int'(exp_rv));
    for (int o = 0; o < NUM_OUT; o++) begin
      if (exp_rv[o] && rd_valid[o]) begin
        int act;
        act = int'(rd_mod[o*MOD_W +: MOD_W]) * NUM_WL + int'(rd_wl[o*WL_W +: WL_W]);
        check(act == exp_rd[o], req, $sformatf("read tag out%0d", o), act, exp_rd[o]);
      end
    end
    if (!v) begin
      check(!wr_grant && !wr_drop, req, "idle grant/drop", int'({wr_grant, wr_drop}), 0);
    end else if (pick < 0) begin
      check(wr_drop && !wr_grant, req, "drop", int'({wr_grant, wr_drop}), 1);
    end else begin
      check(wr_grant && !wr_drop, req, "grant", int'({wr_grant, wr_drop}), 2);
      if (wr_grant)
        check(int'(wr_mod) * NUM_WL + int'(wr_wl) == pick, req, "write slot",
              int'(wr_mod) * NUM_WL + int'(wr_wl), pick);
    end
    // advance model
    for (int o = 0; o < NUM_OUT; o++) if (exp_rv[o]) void'(qs[o].pop_front());
    for (int i = 0; i < SLOTS; i++) if (rel[i]) occ_m[i] = 0;
    if (v && pick >= 0) begin
      occ_m[pick] = 1;
      qs[dest].push_back(pick);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    check(!wr_grant && !wr_drop && rd_valid == '0, "R1", "outputs after reset",
          int'({wr_grant, wr_drop, rd_valid}), 0);
    step(0, 0, '1, "R1");
  endtask

  task automatic t_fill_order();
    for (int k = 0; k < 9; k++) step(1, 3, '0, "R2");
  endtask

  task automatic t_read_order();
    for (int k = 0; k < 9; k++) step(0, 0, 16'h0008, "R6");
    step(0, 0, 16'h0008, "R5");
  endtask

  task automatic t_full_drop();
    for (int k = 0; k < SLOTS; k++) step(1, k % 4, '0, "R4");
    step(1, 5, '0, "R3");
    step(1, 6, '0, "R3");
  endtask

  task automatic t_blocked();
    for (int k = 0; k < 3; k++) step(0, 0, 16'h0000, "R7");
    step(0, 0, 16'hFFF0, "R7");
  endtask

  task automatic t_reuse();
    step(1, 9, 16'h0002, "R8");
  endtask

  task automatic t_multi_read();
    step(0, 0, 16'h0005, "R9");
    step(1, 7, '0, "R4");
    step(1, 7, '0, "R4");
    step(1, 7, '0, "R3");
  endtask

  task automatic t_idle();
    step(0, 0, 16'h0080, "R10");
    step(0, 2, '0, "R10");
    step(1, 2, '0, "R10");
    step(0, 0, 16'h0004, "R6");
  endtask

  initial begin
    foreach (occ_m[i]) occ_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_order();
    t_read_order();
    t_full_drop();
    t_blocked();
    t_reuse();
    t_multi_read();
    t_idle();
    @(negedge clk);
    wr_valid = 1'b0;
    out_free = '0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule